// File: doc/BRIEF.md
# Reconfigurable Circular/Hyperbolic CORDIC Engine

This block is an iterative fixed-point CORDIC engine built as a single shared datapath. One set of adders and shifters and one table of elementary angles serve two trajectories (circular and hyperbolic) and two modes (rotation and vectoring), picked at run time by two select bits. Changing the trajectory only inverts the add/subtract on the x path and switches the angle constants, so no part of the datapath is duplicated.

A caller loads x, y and z with the selects and pulses `start`. The engine then performs one micro-rotation per clock and pulses `done` when the result is ready. The result stays on the outputs until the next accepted start. The trajectory gain is not removed inside the block. Callers pre-scale x and y by the inverse gain when they need sine/cosine, cosh/sinh or exponentials. Vectoring mode gives magnitudes, arctangents, inverse hyperbolic tangents (and therefore logarithms) and square roots.

Top module: `cordic_engine`

## Requirements
- R1: While reset is high and on the first cycle after it, `x_out`, `y_out` and `z_out` read zero and `done` is low. Reset is synchronous and active high.
- R2: A start taken while idle loads the operands. Each step then takes one cycle: 16 steps for circular and 18 steps for hyperbolic. `done` is high during the cycle that follows the clock edge 1+steps after the edge that sampled `start`.
- R3: Circular rotation: x→Kc·(x·cos z − y·sin z), y→Kc·(y·cos z + x·sin z), z→0, each within 12 LSB. Kc is the product of sqrt(1+2^-2i) for i = 0..15. Negative operands and negative angles must work, which needs arithmetic shifts.
- R4: Circular vectoring (x > 0): x→Kc·sqrt(x²+y²), y→0, z→z0+atan(y/x), each within 12 LSB.
- R5: Hyperbolic rotation: x→Kh·(x·cosh z + y·sinh z), y→Kh·(y·cosh z + x·sinh z), z→0, each within 12 LSB. Kh is the product of sqrt(1−2^-2i) over the executed index sequence.
- R6: Hyperbolic vectoring (x > |y|): x→Kh·sqrt(x²−y²), y→0, z→z0+atanh(y/x), each within 12 LSB.
- R7: Operands are 16-bit two's complement with 14 fraction bits. The selects are sampled only when a start is accepted. `traj_sel` 0 chooses circular and 1 chooses hyperbolic. `mode_sel` 0 chooses rotation, where the direction is the sign of z. `mode_sel` 1 chooses vectoring, where the direction is opposite to the sign of y.
- R8: Circular steps use shift indices 0..15 with atan(2^-i). Hyperbolic steps use indices 1..16 with atanh(2^-i), and indices 4 and 13 are each executed twice.
- R9: A start while a computation is running is ignored. The running result, its latency and its selects are unchanged, and no extra `done` follows.
- R10: `done` lasts one cycle. The outputs then hold their values until the next accepted start. A start in the same cycle as `done` is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, taken only when idle |
| traj_sel | input | 1 | 0 circular, 1 hyperbolic |
| mode_sel | input | 1 | 0 rotation, 1 vectoring |
| x_in | input | 16 | Initial x, Q2.14 |
| y_in | input | 16 | Initial y, Q2.14 |
| z_in | input | 16 | Initial angle, Q2.14 (radians) |
| x_out | output | 16 | Result x |
| y_out | output | 16 | Result y |
| z_out | output | 16 | Result z |
| done | output | 1 | One-cycle result-ready pulse |

## Verification
The completion of one computation and the acceptance of the next can fall in the same cycle. The bench provokes this by raising `start` with new operands and selects in the very cycle it sees `done`. It judges the pair by two things. The first result must match its own expected values when popped from the scoreboard. The second must return, after its own trajectory's latency counted from that cycle, with values computed for the new selects. A second overlap is a start during a run: it must leave the running result and its timing intact and must produce no extra `done`.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    localparam int CW = 16;   // word width
    localparam int CF = 14;   // fraction bits of words and angle table

    typedef logic signed [CW-1:0] word_t;

    typedef enum logic { TRAJ_CIRC = 1'b0, TRAJ_HYP = 1'b1 } traj_e;
    typedef enum logic { MODE_ROT  = 1'b0, MODE_VEC = 1'b1 } mode_e;

    typedef struct packed {
        word_t x;
        word_t y;
        word_t z;
    } vec_t;

    // Hyperbolic indices executed twice: 4, 13, 40, ... (k -> 3k+1)
    function automatic logic is_repeat(int unsigned i);
        int unsigned k;
        k = 4;
        for (int n = 0; n < 6; n++) begin
            if (k == i) return 1'b1;
            k = 3 * k + 1;
        end
        return 1'b0;
    endfunction

    function automatic int count_repeats(int unsigned last);
        int c;
        c = 0;
        for (int unsigned i = 1; i <= last; i++)
            if (is_repeat(i)) c++;
        return c;
    endfunction

    // Elementary angles in Q2.14
    function automatic word_t angle_of(traj_e t, int unsigned i);
        word_t a;
        if (t == TRAJ_CIRC) begin
            case (i)
                0: a = 16'sd12868;  1: a = 16'sd7596;  2: a = 16'sd4014;
                3: a = 16'sd2037;   4: a = 16'sd1023;  5: a = 16'sd512;
                6: a = 16'sd256;    7: a = 16'sd128;   8: a = 16'sd64;
                9: a = 16'sd32;    10: a = 16'sd16;   11: a = 16'sd8;
               12: a = 16'sd4;     13: a = 16'sd2;    14: a = 16'sd1;
               15: a = 16'sd1;
                default: a = '0;
            endcase
        end else begin
            case (i)
                1: a = 16'sd9000;   2: a = 16'sd4185;  3: a = 16'sd2059;
                4: a = 16'sd1025;   5: a = 16'sd512;   6: a = 16'sd256;
                7: a = 16'sd128;    8: a = 16'sd64;    9: a = 16'sd32;
               10: a = 16'sd16;    11: a = 16'sd8;    12: a = 16'sd4;
               13: a = 16'sd2;     14: a = 16'sd1;    15: a = 16'sd1;
                default: a = '0;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/cordic_angle_rom.sv
module cordic_angle_rom
    import cordic_pkg::*;
#(
    parameter int IW = 5
) (
    input  traj_e          traj,
    input  logic [IW-1:0]  idx,
    output word_t          angle
);
    always_comb angle = angle_of(traj, int'(idx));
endmodule

// File: rtl/cordic_seq.sv
module cordic_seq
    import cordic_pkg::*;
#(
    parameter int ITER = 16,
    localparam int IW        = $clog2(ITER + 1),
    localparam int MAX_STEPS = ITER + count_repeats(ITER),
    localparam int SW        = $clog2(MAX_STEPS + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  traj_e          traj_new,
    input  traj_e          traj_cur,
    output logic           busy,
    output logic           last_step,
    output logic [IW-1:0]  idx
);
    logic           busy_q, rep_q, rep_pending;
    logic [IW-1:0]  idx_q, final_idx;
    logic [SW-1:0]  steps_q;

    always_comb begin
        final_idx   = (traj_cur == TRAJ_HYP) ? IW'(ITER) : IW'(ITER - 1);
        rep_pending = (traj_cur == TRAJ_HYP) && is_repeat(int'(idx_q)) && !rep_q;
        last_step   = busy_q && !rep_pending && (idx_q == final_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            rep_q   <= 1'b0;
            idx_q   <= '0;
            steps_q <= '0;
        end else if (load) begin
            busy_q  <= 1'b1;
            rep_q   <= 1'b0;
            idx_q   <= (traj_new == TRAJ_HYP) ? IW'(1) : '0;
            steps_q <= '0;
        end else if (busy_q) begin
            steps_q <= steps_q + 1'b1;
            if (last_step) begin
                busy_q <= 1'b0;
            end else if (rep_pending) begin
                rep_q <= 1'b1;
            end else begin
                idx_q <= idx_q + 1'b1;
                rep_q <= 1'b0;
            end
        end
    end

    assign busy = busy_q;
    assign idx  = idx_q;

    // R8
    hyp_index_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && traj_cur == TRAJ_HYP) |-> (idx_q != '0));

    // R2
    step_bound_chk: assert property (@(posedge clk) disable iff (rst)
        steps_q <= SW'(MAX_STEPS));

    // R2
    last_ends_run_chk: assert property (@(posedge clk) disable iff (rst)
        (last_step && !load) |=> !busy_q);
endmodule

// File: rtl/cordic_stage.sv
module cordic_stage
    import cordic_pkg::*;
#(
    parameter int IW = 5
) (
    input  vec_t           v_in,
    input  traj_e          traj,
    input  mode_e          mode,
    input  logic [IW-1:0]  idx,
    input  word_t          angle,
    output vec_t           v_out
);
    word_t xs, ys;
    logic  dir_pos, sub_x;

    always_comb begin
        // arithmetic shifts keep the sign of negative operands
        xs = v_in.x >>> idx;
        ys = v_in.y >>> idx;
        dir_pos = (mode == MODE_ROT) ? ~v_in.z[CW-1] : v_in.y[CW-1];
        // hyperbolic inverts the x-path operation
        sub_x = dir_pos ^ (traj == TRAJ_HYP);
        v_out.x = sub_x   ? v_in.x - ys    : v_in.x + ys;
        v_out.y = dir_pos ? v_in.y + xs    : v_in.y - xs;
        v_out.z = dir_pos ? v_in.z - angle : v_in.z + angle;
    end
endmodule

// File: rtl/cordic_engine.sv
module cordic_engine
    import cordic_pkg::*;
#(
    parameter int ITER = 16,
    localparam int IW = $clog2(ITER + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 traj_sel,
    input  logic                 mode_sel,
    input  logic signed [15:0]   x_in,
    input  logic signed [15:0]   y_in,
    input  logic signed [15:0]   z_in,
    output logic signed [15:0]   x_out,
    output logic signed [15:0]   y_out,
    output logic signed [15:0]   z_out,
    output logic                 done
);
    vec_t           vec_q, vec_nx;
    traj_e          traj_q;
    mode_e          mode_q;
    logic           done_q, busy, last_step, accept;
    logic [IW-1:0]  idx;
    word_t          angle;

    assign accept = start && !busy;

    cordic_seq #(.ITER(ITER)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .traj_new  (traj_e'(traj_sel)),
        .traj_cur  (traj_q),
        .busy      (busy),
        .last_step (last_step),
        .idx       (idx)
    );

    cordic_angle_rom #(.IW(IW)) u_rom (
        .traj  (traj_q),
        .idx   (idx),
        .angle (angle)
    );

    cordic_stage #(.IW(IW)) u_stage (
        .v_in  (vec_q),
        .traj  (traj_q),
        .mode  (mode_q),
        .idx   (idx),
        .angle (angle),
        .v_out (vec_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q  <= '0;
            traj_q <= TRAJ_CIRC;
            mode_q <= MODE_ROT;
            done_q <= 1'b0;
        end else begin
            done_q <= last_step;
            if (accept) begin
                vec_q  <= '{x: x_in, y: y_in, z: z_in};
                traj_q <= traj_e'(traj_sel);
                mode_q <= mode_e'(mode_sel);
            end else if (busy) begin
                vec_q  <= vec_nx;
            end
        end
    end

    assign x_out = vec_q.x;
    assign y_out = vec_q.y;
    assign z_out = vec_q.z;
    assign done  = done_q;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(vec_q));

    // R9
    ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(traj_q) && $stable(mode_q)));

    // R2
    done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($past(busy) && !busy));
endmodule

// File: tb/cordic_engine_test.sv
module cordic_engine_test;

    localparam real SC  = 16384.0;
    localparam int  TOL = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, traj_sel = 1'b0, mode_sel = 1'b0;
    logic signed [15:0] x_in = '0, y_in = '0, z_in = '0;
    logic signed [15:0] x_out, y_out, z_out;
    logic done;

    int cyc = 0;
    int n_chk = 0, n_fail = 0;
    real kc, kh;

    int    qx[$], qy[$], qz[$], qc[$];
    string qtag[$];

    always #10 clk = ~clk;          // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    cordic_engine uut (
        .clk(clk), .rst(rst), .start(start), .traj_sel(traj_sel),
        .mode_sel(mode_sel), .x_in(x_in), .y_in(y_in), .z_in(z_in),
        .x_out(x_out), .y_out(y_out), .z_out(z_out), .done(done)
    );

    function automatic int to_fx(real r);
        return $rtoi(r * SC + ((r >= 0.0) ? 0.5 : -0.5));
    endfunction

    task automatic check_val(string req, string what, int act, int exp, int tol);
        int d;
        d = act - exp;
        if (d < 0) d = -d;
        n_chk++;
        if (d > tol) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (tol %0d)", req, what, act, exp, tol);
        end
    endtask

    // Driver: called at a falling edge; pushes the expected item, pulses start.
    task automatic launch(real xr, real yr, real zr, bit hyp, bit vec, string tag);
        real xq, yq, zq, ex, ey, ez, g;
        int steps;
        xq = real'(to_fx(xr)) / SC;
        yq = real'(to_fx(yr)) / SC;
        zq = real'(to_fx(zr)) / SC;
        g = hyp ? kh : kc;
        steps = hyp ? 18 : 16;
        if (!hyp && !vec) begin
            ex = g * (xq * $cos(zq) - yq * $sin(zq));
            ey = g * (yq * $cos(zq) + xq * $sin(zq));
            ez = 0.0;
        end else if (!hyp) begin
            ex = g * $sqrt(xq * xq + yq * yq);
            ey = 0.0;
            ez = zq + $atan(yq / xq);
        end else if (!vec) begin
            ex = g * (xq * $cosh(zq) + yq * $sinh(zq));
            ey = g * (yq * $cosh(zq) + xq * $sinh(zq));
            ez = 0.0;
        end else begin
            ex = g * $sqrt(xq * xq - yq * yq);
            ey = 0.0;
            ez = zq + $atanh(yq / xq);
        end
        qx.push_back(to_fx(ex));
        qy.push_back(to_fx(ey));
        qz.push_back(to_fx(ez));
        qc.push_back(cyc + 1 + steps);
        qtag.push_back(tag);
        x_in = 16'(to_fx(xr)); y_in = 16'(to_fx(yr)); z_in = 16'(to_fx(zr));
        traj_sel = hyp; mode_sel = vec; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // R10: after done, outputs hold and done stays low
    task automatic hold_check();
        int hx, hy, hz;
        hx = x_out; hy = y_out; hz = z_out;
        repeat (5) @(negedge clk);
        check_val("R10", "held x", x_out, hx, 0);
        check_val("R10", "held y", y_out, hy, 0);
        check_val("R10", "held z", z_out, hz, 0);
        check_val("R10", "done low after pulse", int'(done), 0, 0);
    endtask

    // Monitor: pops and compares as results appear
    always @(negedge clk) begin
        if (!rst && done) begin
            if (qx.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R9 unexpected done: actual 1 expected 0");
            end else begin
                string t;
                t = qtag.pop_front();
                check_val(t, "x", x_out, qx.pop_front(), TOL);
                check_val(t, "y", y_out, qy.pop_front(), TOL);
                check_val(t, "z", z_out, qz.pop_front(), TOL);
                check_val("R2", "done cycle", cyc, qc.pop_front(), 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R8: gains over the executed index sequences
        kc = 1.0;
        for (int i = 0; i < 16; i++) kc = kc * $sqrt(1.0 + 2.0 ** (-2.0 * i));
        kh = 1.0;
        for (int i = 1; i <= 16; i++) begin
            kh = kh * $sqrt(1.0 - 2.0 ** (-2.0 * i));
            if (i == 4 || i == 13) kh = kh * $sqrt(1.0 - 2.0 ** (-2.0 * i));
        end

        repeat (3) @(negedge clk);
        // R1: reset values
        check_val("R1", "x in reset", x_out, 0, 0);
        check_val("R1", "done in reset", int'(done), 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check_val("R1", "x after reset", x_out, 0, 0);
        check_val("R1", "y after reset", y_out, 0, 0);
        check_val("R1", "z after reset", z_out, 0, 0);
        check_val("R1", "done after reset", int'(done), 0, 0);

        // R3: circular rotation, positive and negative angle (arithmetic shift)
        launch(1.0 / kc, 0.0, 0.7, 0, 0, "R3 sin/cos +");
        wait_done(); hold_check();
        launch(-0.5 / kc, 0.3 / kc, -1.2, 0, 0, "R3 rotate negative");
        wait_done();

        // R4: circular vectoring with nonzero initial angle
        launch(0.9, 0.6, 0.25, 0, 1, "R4 magnitude/atan");
        wait_done();
        launch(0.7, -0.8, 0.0, 0, 1, "R4 negative y");
        wait_done();

        // R5: hyperbolic rotation (cosh/sinh), R8 via latency 18
        launch(1.0 / kh, 0.0, 1.0, 1, 0, "R5 cosh/sinh +");
        wait_done(); hold_check();
        launch(1.0 / kh, 0.0, -0.8, 1, 0, "R5 cosh/sinh -");
        wait_done();

        // R6: hyperbolic vectoring (atanh, square root of 0.5 via a+1/4, a-1/4)
        launch(1.0, 0.5, 0.0, 1, 1, "R6 atanh");
        wait_done();
        launch(0.75, 0.25, 0.1, 1, 1, "R6 sqrt");
        wait_done();

        // R9: start during a run with other operands and selects is ignored
        launch(1.0 / kc, 0.0, 0.4, 0, 0, "R9 run kept");
        repeat (5) @(negedge clk);
        x_in = 16'sd1000; y_in = 16'sd500; z_in = 16'sd300;
        traj_sel = 1'b1; mode_sel = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        hold_check();

        // R10/R7: start in the done cycle is accepted, new selects take effect
        launch(1.0 / kc, 0.0, -0.3, 0, 0, "R10 first of pair");
        wait_done();
        launch(1.0, -0.4, 0.0, 1, 1, "R7 second of pair hyp vec");
        wait_done();
        @(negedge clk);

        repeat (25) @(negedge clk);
        check_val("R9", "pending results", qx.size(), 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule